// File: doc/BRIEF.md
# DC Bias Duty-Cycle Corrector

This block sits between the volt-second error integrator and the PWM stage of a full-bridge converter. Once per switching period it looks at the signed volt-second integral and decides whether the transformer is drifting toward saturation on either side. When the integral lies above a programmable upper threshold, the next period is given a shorter positive half-wave and a longer negative half-wave. When it lies below a programmable lower threshold, the adjustment goes the other way. Inside the band, both half-waves get the nominal duty command.

The adjustment is always symmetric. One half-wave loses exactly the counts that the other gains, so the period never takes a one-sided step. The step is programmable. The block shrinks it as needed so that neither duty count leaves the range 0 to 2500 clock counts. New duty values and the active mode are registered only on the period-done strobe, so the PWM stage never sees a change mid-period.

Top module: `dcb_duty_corrector`

## Requirements
- R1: On a strobe with integral strictly greater than the positive threshold, the mode output becomes 2'b01, the positive duty becomes nominal minus step and the negative duty becomes nominal plus step.
- R2: On a strobe with integral strictly less than the negative threshold, the mode output becomes 2'b10, the positive duty becomes nominal plus step and the negative duty becomes nominal minus step.
- R3: On a strobe with integral within the band (equal to a threshold counts as inside), the mode output becomes 2'b00 and both duties equal the nominal command.
- R4: The applied step is the smallest of the programmed step, the nominal duty, and 2500 minus the nominal duty. Both duties therefore stay within 0 to 2500, and the correction stays symmetric.
- R5: A nominal command above 2500 is treated as 2500.
- R6: Outputs change only on a clock edge where the strobe is high. Changes to integral, thresholds, step or nominal without a strobe have no effect on the outputs.
- R7: If the integral is both above the positive threshold and below the negative threshold (misordered thresholds), positive correction (2'b01) takes priority.
- R8: After reset, both duties are 0 and the mode output is 2'b00.
- R9: Results are visible on the outputs one clock cycle after the strobe: the edge that samples the strobe high updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_done | input | 1 | One-cycle strobe at the end of each switching period |
| vs_int | input | INT_W (24) | Signed volt-second error integral |
| duty_nom | input | DUTY_W (12) | Nominal duty command in clock counts |
| thr_pos | input | INT_W (24) | Signed positive correction threshold |
| thr_neg | input | INT_W (24) | Signed negative correction threshold |
| step_size | input | DUTY_W (12) | Requested correction step in clock counts |
| duty_pos | output | DUTY_W (12) | Positive half-wave duty for the next period |
| duty_neg | output | DUTY_W (12) | Negative half-wave duty for the next period |
| corr_mode | output | 2 | Active correction: 00 none, 01 positive, 10 negative |

## Verification
Every result is due exactly one cycle after the strobe: the rising edge that samples `period_done` high loads the duties and the mode, and nothing else moves them. The bench drives inputs just after a falling edge. A monitor notes on each rising edge whether the strobe was sampled, then compares the queued expectation at the very next falling edge. A late or early update is therefore caught. For the ignored-input case, the bench holds the strobe low while changing every other input for several cycles and compares the outputs with the last expected values.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    typedef enum logic [1:0] {
        DCB_NONE = 2'b00,
        DCB_POS  = 2'b01,
        DCB_NEG  = 2'b10
    } dcb_mode_e;

endpackage

// File: rtl/dcb_classify.sv
module dcb_classify
    import dcb_pkg::*;
#(
    parameter int INT_W = 24
) (
    input  logic signed [INT_W-1:0] vs_int,
    input  logic signed [INT_W-1:0] thr_pos,
    input  logic signed [INT_W-1:0] thr_neg,
    output dcb_mode_e               mode
);

    logic over_pos;
    logic under_neg;

    assign over_pos  = (vs_int > thr_pos);
    assign under_neg = (vs_int < thr_neg);

    // positive side wins when both conditions hold
    always_comb begin
        if (over_pos) begin
            mode = DCB_POS;
        end else if (under_neg) begin
            mode = DCB_NEG;
        end else begin
            mode = DCB_NONE;
        end
    end

    always_comb begin
        assert ($onehot0(mode)) else $error("AST_CLASS_LEGAL");  // R1
    end

endmodule

// File: rtl/dcb_step_limit.sv
module dcb_step_limit #(
    parameter int DUTY_W   = 12,
    parameter int DUTY_MAX = 2500
) (
    input  logic [DUTY_W-1:0] duty_nom,
    input  logic [DUTY_W-1:0] step_req,
    output logic [DUTY_W-1:0] nom_sat,
    output logic [DUTY_W-1:0] step_sat
);

    localparam logic [DUTY_W-1:0] MAX_V = DUTY_W'(DUTY_MAX);

    logic [DUTY_W-1:0] headroom;
    logic [DUTY_W-1:0] floor_lim;

    always_comb begin
        nom_sat   = (duty_nom > MAX_V) ? MAX_V : duty_nom;
        headroom  = MAX_V - nom_sat;
        floor_lim = (nom_sat < headroom) ? nom_sat : headroom;
        step_sat  = (step_req < floor_lim) ? step_req : floor_lim;
    end

    always_comb begin
        assert ({1'b0, nom_sat} + {1'b0, step_sat} <= {1'b0, MAX_V})
            else $error("AST_STEP_HEADROOM");  // R4
        assert (step_sat <= nom_sat) else $error("AST_STEP_FLOOR");  // R4
    end

endmodule

// File: rtl/dcb_duty_corrector.sv
module dcb_duty_corrector
    import dcb_pkg::*;
#(
    parameter int INT_W    = 24,
    parameter int DUTY_W   = 12,
    parameter int DUTY_MAX = 2500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     period_done,
    input  logic signed [INT_W-1:0]  vs_int,
    input  logic [DUTY_W-1:0]        duty_nom,
    input  logic signed [INT_W-1:0]  thr_pos,
    input  logic signed [INT_W-1:0]  thr_neg,
    input  logic [DUTY_W-1:0]        step_size,
    output logic [DUTY_W-1:0]        duty_pos,
    output logic [DUTY_W-1:0]        duty_neg,
    output logic [1:0]               corr_mode
);

    localparam logic [DUTY_W-1:0] MAX_V = DUTY_W'(DUTY_MAX);

    typedef struct packed {
        logic [DUTY_W-1:0] pos;
        logic [DUTY_W-1:0] neg;
        dcb_mode_e         mode;
    } corr_state_t;

    corr_state_t st_d, st_q;
    dcb_mode_e   mode_now;
    logic [DUTY_W-1:0] nom_sat;
    logic [DUTY_W-1:0] step_sat;

    dcb_classify #(.INT_W(INT_W)) u_class (
        .vs_int  (vs_int),
        .thr_pos (thr_pos),
        .thr_neg (thr_neg),
        .mode    (mode_now)
    );

    dcb_step_limit #(.DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)) u_step (
        .duty_nom (duty_nom),
        .step_req (step_size),
        .nom_sat  (nom_sat),
        .step_sat (step_sat)
    );

    always_comb begin
        st_d = st_q;
        if (period_done) begin
            st_d.mode = mode_now;
            unique case (mode_now)
                DCB_POS: begin
                    st_d.pos = nom_sat - step_sat;
                    st_d.neg = nom_sat + step_sat;
                end
                DCB_NEG: begin
                    st_d.pos = nom_sat + step_sat;
                    st_d.neg = nom_sat - step_sat;
                end
                default: begin
                    st_d.pos = nom_sat;
                    st_d.neg = nom_sat;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: '0, neg: '0, mode: DCB_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_pos  = st_q.pos;
    assign duty_neg  = st_q.neg;
    assign corr_mode = st_q.mode;

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !period_done |=> ($stable(duty_pos) && $stable(duty_neg) && $stable(corr_mode)));  // R6
    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_pos <= MAX_V) && (duty_neg <= MAX_V));  // R4
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(corr_mode));  // R1
    AST_POS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_mode == 2'b01) |-> (duty_pos <= duty_neg));  // R1
    AST_NEG_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_mode == 2'b10) |-> (duty_neg <= duty_pos));  // R2
    AST_BAND_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_mode == 2'b00) |-> (duty_pos == duty_neg));  // R3
    AST_POS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && (vs_int > thr_pos)) |=> (corr_mode == 2'b01));  // R7

endmodule

// File: tb/sim_dcb_duty_corrector.sv
module sim_dcb_duty_corrector;

    localparam int INT_W  = 24;
    localparam int DUTY_W = 12;
    localparam int LIM    = 2500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_done = 1'b0;
    logic signed [INT_W-1:0] vs_int = '0;
    logic [DUTY_W-1:0] duty_nom = '0;
    logic signed [INT_W-1:0] thr_pos = '0;
    logic signed [INT_W-1:0] thr_neg = '0;
    logic [DUTY_W-1:0] step_size = '0;
    logic [DUTY_W-1:0] duty_pos;
    logic [DUTY_W-1:0] duty_neg;
    logic [1:0] corr_mode;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int p;
        int n;
        int m;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t last_e;

    always #2 clk = ~clk;

    dcb_duty_corrector #(.INT_W(INT_W), .DUTY_W(DUTY_W), .DUTY_MAX(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .period_done(period_done), .vs_int(vs_int),
        .duty_nom(duty_nom), .thr_pos(thr_pos), .thr_neg(thr_neg),
        .step_size(step_size), .duty_pos(duty_pos), .duty_neg(duty_neg),
        .corr_mode(corr_mode)
    );

    function automatic exp_t model(int i, int nom, int tp, int tn, int st, string tag);
        exp_t e;
        int nc = (nom > LIM) ? LIM : nom;
        int s = st;
        if (s > nc) s = nc;
        if (s > LIM - nc) s = LIM - nc;
        e.tag = tag;
        if (i > tp) begin
            e.m = 1; e.p = nc - s; e.n = nc + s;
        end else if (i < tn) begin
            e.m = 2; e.p = nc + s; e.n = nc - s;
        end else begin
            e.m = 0; e.p = nc; e.n = nc;
        end
        return e;
    endfunction

    task automatic compare(exp_t e, string ctx);
        total++;
        if (duty_pos !== DUTY_W'(e.p) || duty_neg !== DUTY_W'(e.n) || corr_mode !== 2'(e.m)) begin
            bad++;
            $display("FAIL %s %s: got pos=%0d neg=%0d mode=%0d exp pos=%0d neg=%0d mode=%0d",
                     e.tag, ctx, duty_pos, duty_neg, corr_mode, e.p, e.n, e.m);
        end
    endtask

    // driver: one strobe with the given inputs, expectation queued
    task automatic apply(int i, int nom, int tp, int tn, int st, string tag);
        @(negedge clk);
        #1;
        vs_int = INT_W'(i); duty_nom = DUTY_W'(nom);
        thr_pos = INT_W'(tp); thr_neg = INT_W'(tn); step_size = DUTY_W'(st);
        period_done = 1'b1;
        exp_q.push_back(model(i, nom, tp, tn, st, tag));
        @(negedge clk);
        #1;
        period_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: strobe seen at a rising edge -> result due at next falling edge (R9)
    initial begin
        forever begin
            bit cap;
            @(posedge clk);
            cap = period_done;
            @(negedge clk);
            if (cap) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R9: strobe with no expectation, got pos=%0d exp none", duty_pos);
                end else begin
                    last_e = exp_q.pop_front();
                    compare(last_e, "R9 one cycle after strobe");
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t rst_e;
        repeat (3) @(negedge clk);
        rst_e.p = 0; rst_e.n = 0; rst_e.m = 0; rst_e.tag = "R8";
        compare(rst_e, "reset state");
        #1 rst_n = 1'b1;
        @(negedge clk);
        compare(rst_e, "after reset release");

        apply(0, 1250, 1000, -1000, 50, "R3");
        apply(1500, 1250, 1000, -1000, 50, "R1");
        apply(-1500, 1250, 1000, -1000, 50, "R2");
        apply(1000, 1250, 1000, -1000, 50, "R3");
        apply(-1000, 1250, 1000, -1000, 50, "R3");
        apply(1001, 1250, 1000, -1000, 50, "R1");
        apply(-1001, 800, 1000, -1000, 200, "R2");
        apply(2000, 30, 1000, -1000, 100, "R4");
        apply(-2000, 2480, 1000, -1000, 100, "R4");
        apply(-2000, 0, 1000, -1000, 100, "R4");
        apply(0, 3000, 1000, -1000, 10, "R5");
        apply(5000, 4000, 1000, -1000, 10, "R5");
        apply(0, 1000, -10, 10, 40, "R7");
        apply(-50, 1000, -10, 10, 40, "R7");

        // R6: strobe once, then move every input without a strobe
        apply(3000, 1500, 1000, -1000, 75, "R6");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            vs_int = INT_W'(-5000 + k); duty_nom = DUTY_W'(100 * k);
            thr_pos = INT_W'(k); thr_neg = INT_W'(-k); step_size = DUTY_W'(300);
        end
        repeat (3) @(negedge clk);
        last_e.tag = "R6";
        compare(last_e, "inputs moved without strobe");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R9: got %0d pending results exp 0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule